// File: doc/BRIEF.md
# Carry-Flag Bit Transfer Unit

This block moves a single bit between a carry flag and one addressed bit of a nibble-wide store. That store is a data memory on an external synchronous port, plus a small window of I/O port nibbles held inside the block. A sequencer issues one operation at a time: load a bit into carry, store carry into a bit, force carry to one, or force carry to zero.

The operand bit can be named in three ways:
- **Direct:** an immediate nibble address with an immediate bit number.
- **Register-indexed:** the upper bits of the immediate are joined with two bits of the L register, and the lowest two bits of L choose the bit.
- **Page-plus-offset:** the H register provides the upper nibble of the address.

Stores are read-modify-write on the nibble. A store into a port bit also turns that pin into an output.

Every operation takes the same fixed sequence. Busy is high while it runs. Done pulses on the cycle in which the new carry is visible. A new operation may be issued on that done cycle.

Top module: `carry_bit_xfer`

## Requirements
- R1: After a synchronous active-low reset the following are all 0: carry, busy, done, mem_rd, mem_wr, every pin_oe bit and every pin_out bit.
- R2: Direct mode (mode 0) uses imm_addr as the nibble address and imm_bit as the bit number. Mode 3 behaves as mode 0.
- R3: Register-indexed mode (mode 1) forms the address as {imm_addr[7:2], reg_l[3:2]} and the bit number as reg_l[1:0]. Example: imm_addr F1h with reg_l 0001b gives address F0h, bit 1.
- R4: Page mode (mode 2) forms the address as {reg_h, imm_addr[3:0]} and takes the bit number from imm_bit. Example: reg_h 2h with offset 0h and bit 3 gives address 20h, bit 3.
- R5: Operation 0 (load) copies the addressed bit into carry. A port bit configured as an input and reading logic 0 clears carry.
- R6: Operation 1 (store) writes carry into the addressed bit and leaves the other three bits of the nibble unchanged. For a memory address, mem_wr is asserted two cycles after mem_rd for the same address.
- R7: A store to a port bit sets that bit's output latch to carry and its direction bit to 1 (output, seen on pin_oe). No other pin's direction changes.
- R8: A port bit reads back its output latch when its direction bit is 1, and its pin_in value when its direction bit is 0.
- R9: Operation 2 sets carry to 1. Operation 3 clears carry to 0.
- R10: When start is accepted (start high while busy is low), done rises four cycles later for exactly one cycle. Carry changes only in a done cycle.
- R11: Nibble addresses F0h to F3h are ports 0 to 3 and never drive mem_rd or mem_wr. All other addresses use the memory port. Set and clear operations touch neither memory nor ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue an operation (accepted when busy is low) |
| op | input | 2 | 0 load, 1 store, 2 set carry, 3 clear carry |
| mode | input | 2 | 0 direct, 1 register-indexed, 2 page-plus-offset, 3 direct |
| imm_addr | input | 8 | Immediate nibble address |
| imm_bit | input | 2 | Immediate bit number |
| reg_l | input | 4 | L register value |
| reg_h | input | 4 | H register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Carry flag |
| mem_addr | output | 8 | Memory nibble address |
| mem_rd | output | 1 | Memory read strobe, data returned the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write nibble |
| mem_rdata | input | 4 | Memory read nibble |
| pin_in | input | 16 | Pin levels, 4 bits per port, port 0 lowest |
| pin_out | output | 16 | Port output latches |
| pin_oe | output | 16 | Port direction bits, 1 means output |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. The bench issues each new operation in the cycle where done is high. A set or clear of carry is immediately followed by a store or a load, so the follow-on operation must use the carry value that was just finished. The scoreboard's reference carry is updated in issue order, and the bench compares it with the stored nibble or the loaded carry. A second coincidence is that a port bit becomes an output while its pin input holds the opposite level. This is provoked by storing into that bit and then reading it back, and the readback must return the latch value.

// File: rtl/carry_bit_xfer_pkg.sv
// Shared encodings for the carry-flag bit transfer unit.
package carry_bit_xfer_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_SETC  = 2'd2,
        OP_CLRC  = 2'd3
    } xfer_op_e;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,
        AM_REGIDX = 2'd1,
        AM_PAGE   = 2'd2,
        AM_ALT    = 2'd3
    } addr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_MERGE = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } xfer_state_e;

endpackage

// File: rtl/bit_addr_form.sv
// Forms the nibble address and bit number of the operand from the mode,
// the immediate fields and the L/H registers.
// Assumes NW is a power of two with NW >= 2*log2(NW), and an address
// width of two nibbles.
module bit_addr_form
    import carry_bit_xfer_pkg::*;
#(
    parameter int NW = 4,
    localparam int AW = 2 * NW,
    localparam int BW = $clog2(NW)
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] imm_addr,
    input  logic [BW-1:0] imm_bit,
    input  logic [NW-1:0] reg_l,
    input  logic [NW-1:0] reg_h,
    output logic [AW-1:0] eff_addr,
    output logic [BW-1:0] eff_bit
);

    // Select the address source for the requested mode.
    always_comb begin
        case (addr_mode_e'(mode))
            AM_REGIDX: begin
                eff_addr = {imm_addr[AW-1:BW], reg_l[2*BW-1:BW]};
                eff_bit  = reg_l[BW-1:0];
            end
            AM_PAGE: begin
                eff_addr = {reg_h, imm_addr[NW-1:0]};
                eff_bit  = imm_bit;
            end
            default: begin
                eff_addr = imm_addr;
                eff_bit  = imm_bit;
            end
        endcase
    end

endmodule

// File: rtl/port_nibble_bank.sv
// Holds the output latch and direction bits of NP nibble-wide ports and
// returns the effective read value of any one of them.
// Assumes wr_idx and rd_idx are below NP whenever they are used.
module port_nibble_bank #(
    parameter int NW = 4,
    parameter int NP = 4,
    localparam int BW  = $clog2(NW),
    localparam int PIW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [PIW-1:0] wr_idx,
    input  logic [BW-1:0]  wr_bit,
    input  logic           wr_val,
    input  logic [PIW-1:0] rd_idx,
    input  logic [NP*NW-1:0] pin_in,
    output logic [NW-1:0]  rd_nib,
    output logic [NP*NW-1:0] pin_out,
    output logic [NP*NW-1:0] pin_oe
);

    logic [NW-1:0] eff [NP];
    logic [PIW+BW-1:0] wr_pos;

    assign wr_pos = {wr_idx, wr_bit};

    for (genvar p = 0; p < NP; p++) begin : g_port
        // Update latch and direction of this port on a bit store.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pin_out[p*NW +: NW] <= '0;
                pin_oe[p*NW +: NW]  <= '0;
            end else if (wr_en && (wr_idx == PIW'(p))) begin
                pin_out[p*NW + int'(wr_bit)] <= wr_val;
                pin_oe[p*NW + int'(wr_bit)]  <= 1'b1;
            end
        end

        // Per bit: the latch when the bit drives, the pin level otherwise.
        assign eff[p] = (pin_oe[p*NW +: NW] & pin_out[p*NW +: NW])
                      | (~pin_oe[p*NW +: NW] & pin_in[p*NW +: NW]);
    end

    // Pick the nibble being read.
    always_comb begin
        rd_nib = '0;
        for (int p = 0; p < NP; p++)
            if (rd_idx == PIW'(p)) rd_nib = eff[p];
    end

    a_r7_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pin_oe[$past(wr_pos)]);
    a_r7_latch_val: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pin_out[$past(wr_pos)] == $past(wr_val)));
    a_r7_dir_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe));

endmodule

// File: rtl/carry_bit_xfer.sv
// Carry-flag bit transfer unit. It sequences a load, store, set or clear
// of carry through a fixed four-cycle read/merge/write sequence. Memory is
// reached via a synchronous port whose read data arrives one cycle after
// mem_rd. Port nibbles live in an internal bank.
// Assumes the sequencer holds the operands only for the start cycle.
module carry_bit_xfer
    import carry_bit_xfer_pkg::*;
#(
    parameter int NW = 4,
    parameter int NP = 4,
    parameter int PORT_BASE = 240,
    localparam int AW  = 2 * NW,
    localparam int BW  = $clog2(NW),
    localparam int PIW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [1:0]       mode,
    input  logic [AW-1:0]    imm_addr,
    input  logic [BW-1:0]    imm_bit,
    input  logic [NW-1:0]    reg_l,
    input  logic [NW-1:0]    reg_h,
    output logic             busy,
    output logic             done,
    output logic             carry,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [NW-1:0]    mem_wdata,
    input  logic [NW-1:0]    mem_rdata,
    input  logic [NP*NW-1:0] pin_in,
    output logic [NP*NW-1:0] pin_out,
    output logic [NP*NW-1:0] pin_oe
);

    xfer_state_e   state;
    xfer_op_e      op_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] bit_q;
    logic          port_q;
    logic [NW-1:0] nib_q;
    logic          carry_q;

    logic [AW-1:0]  eff_addr;
    logic [BW-1:0]  eff_bit;
    logic           eff_is_port;
    logic [AW:0]    rel_addr;
    logic [PIW-1:0] port_idx;
    logic [NW-1:0]  port_nib;
    logic [NW-1:0]  merged;
    logic           accept;
    logic           needs_read;
    logic           do_store;

    bit_addr_form #(.NW(NW)) u_addr (
        .mode    (mode),
        .imm_addr(imm_addr),
        .imm_bit (imm_bit),
        .reg_l   (reg_l),
        .reg_h   (reg_h),
        .eff_addr(eff_addr),
        .eff_bit (eff_bit)
    );

    // Decide whether the formed address lies in the port window.
    always_comb begin
        rel_addr    = {1'b0, eff_addr} - (AW+1)'(PORT_BASE);
        eff_is_port = ({1'b0, eff_addr} >= (AW+1)'(PORT_BASE))
                   && (rel_addr < (AW+1)'(NP));
    end

    assign port_idx = PIW'(addr_q - AW'(PORT_BASE));

    // Replace the selected bit of the fetched nibble with carry.
    always_comb begin
        merged = nib_q;
        merged[bit_q] = carry_q;
    end

    assign accept     = start && !busy;
    assign needs_read = (op_q == OP_LOAD) || (op_q == OP_STORE);
    assign do_store   = (state == ST_WRITE) && (op_q == OP_STORE);

    port_nibble_bank #(.NW(NW), .NP(NP)) u_ports (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_store && port_q),
        .wr_idx (port_idx),
        .wr_bit (bit_q),
        .wr_val (carry_q),
        .rd_idx (port_idx),
        .pin_in (pin_in),
        .rd_nib (port_nib),
        .pin_out(pin_out),
        .pin_oe (pin_oe)
    );

    // Step the operation sequence and hold the operand context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_LOAD;
            addr_q <= '0;
            bit_q  <= '0;
            port_q <= 1'b0;
            nib_q  <= '0;
        end else begin
            case (state)
                ST_READ:  state <= ST_MERGE;
                ST_MERGE: begin
                    nib_q <= port_q ? port_nib : mem_rdata;
                    state <= ST_WRITE;
                end
                ST_WRITE: state <= ST_DONE;
                default: begin
                    if (accept) begin
                        op_q   <= xfer_op_e'(op);
                        addr_q <= eff_addr;
                        bit_q  <= eff_bit;
                        port_q <= eff_is_port;
                        state  <= ST_READ;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Update carry only as the write step ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (state == ST_WRITE) begin
            case (op_q)
                OP_LOAD:  carry_q <= nib_q[bit_q];
                OP_SETC:  carry_q <= 1'b1;
                OP_CLRC:  carry_q <= 1'b0;
                default:  carry_q <= carry_q;
            endcase
        end
    end

    assign busy      = (state == ST_READ) || (state == ST_MERGE) || (state == ST_WRITE);
    assign done      = (state == ST_DONE);
    assign carry     = carry_q;
    assign mem_addr  = addr_q;
    assign mem_rd    = (state == ST_READ) && needs_read && !port_q;
    assign mem_wr    = do_store && !port_q;
    assign mem_wdata = merged;

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_carry_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry) |-> done);
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r6_rmw_order: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));
    a_r6_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ nib_q) <= 1));
    a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/tb_carry_bit_xfer.sv
module tb_carry_bit_xfer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0, mode = '0;
    logic [7:0]  imm_addr = '0;
    logic [1:0]  imm_bit = '0;
    logic [3:0]  reg_l = '0, reg_h = '0;
    logic        busy, done, carry;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [3:0]  mem_wdata;
    logic [3:0]  mem_rdata = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [3:0] mem [256];
    logic [3:0] ref_mem [256];
    logic [3:0] ref_lat [4];
    logic [3:0] ref_dir [4];
    logic       ref_carry = 1'b0;

    logic       carry_q [$];
    string      creq_q [$];
    logic [11:0] wr_q [$];

    carry_bit_xfer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
        .imm_addr(imm_addr), .imm_bit(imm_bit), .reg_l(reg_l), .reg_h(reg_h),
        .busy(busy), .done(done), .carry(carry),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memory model: read data one cycle after mem_rd.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items as the design completes them.
    logic prev_carry = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (carry !== prev_carry) check("R10 carry changes only with done", done, 1);
            prev_carry = carry;
            if (done) begin
                if (carry_q.size() == 0) check("R10 unexpected done", 1, 0);
                else check(creq_q.pop_front(), carry, carry_q.pop_front());
            end
            if (mem_wr) begin
                if (wr_q.size() == 0) check("R11 unexpected mem_wr", {mem_addr, mem_wdata}, 0);
                else check("R6 memory write addr/data", {mem_addr, mem_wdata}, wr_q.pop_front());
            end
            if ((mem_rd || mem_wr) && mem_addr >= 8'hF0 && mem_addr <= 8'hF3)
                check("R11 port address on memory port", mem_addr, 0);
        end
    end

    // Driver: compute expectations from the requirements, then issue.
    task automatic do_op(input logic [1:0] o, input logic [1:0] m, input logic [7:0] a,
                         input logic [1:0] b, input logic [3:0] l, input logic [3:0] h,
                         input string req);
        logic [7:0] ea;
        logic [1:0] eb;
        logic [3:0] nib;
        int p;
        int lat;
        case (m)
            2'd1: begin ea = {a[7:2], l[3:2]}; eb = l[1:0]; end
            2'd2: begin ea = {h, a[3:0]}; eb = b; end
            default: begin ea = a; eb = b; end
        endcase
        p = int'(ea) - 240;
        case (o)
            2'd0: begin
                if (p >= 0 && p < 4)
                    ref_carry = ref_dir[p][eb] ? ref_lat[p][eb] : pin_in[p*4 + int'(eb)];
                else
                    ref_carry = ref_mem[ea][eb];
            end
            2'd1: begin
                if (p >= 0 && p < 4) begin
                    ref_lat[p][eb] = ref_carry;
                    ref_dir[p][eb] = 1'b1;
                end else begin
                    nib = ref_mem[ea];
                    nib[eb] = ref_carry;
                    ref_mem[ea] = nib;
                    wr_q.push_back({ea, nib});
                end
            end
            2'd2: ref_carry = 1'b1;
            default: ref_carry = 1'b0;
        endcase
        carry_q.push_back(ref_carry);
        creq_q.push_back(req);
        op = o; mode = m; imm_addr = a; imm_bit = b; reg_l = l; reg_h = h;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R10 done latency", lat, 4);
    endtask

    task automatic setc(); do_op(2'd2, 2'd0, 8'h00, 2'd0, 4'h0, 4'h0, "R9 set carry"); endtask
    task automatic clrc(); do_op(2'd3, 2'd0, 8'h00, 2'd0, 4'h0, 4'h0, "R9 clear carry"); endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 4'(i * 7 + 3);
            ref_mem[i] = 4'(i * 7 + 3);
        end
        mem[8'h37] = 4'b1010; ref_mem[8'h37] = 4'b1010;
        mem[8'h20] = 4'b1000; ref_mem[8'h20] = 4'b1000;
        mem[8'h25] = 4'b0001; ref_mem[8'h25] = 4'b0001;
        for (int i = 0; i < 4; i++) begin ref_lat[i] = '0; ref_dir[i] = '0; end

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset carry", carry, 0);
        check("R1 reset busy/done", {busy, done}, 0);
        check("R1 reset mem strobes", {mem_rd, mem_wr}, 0);
        check("R1 reset pin_oe", pin_oe, 0);
        check("R1 reset pin_out", pin_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R5: direct loads from memory
        do_op(2'd0, 2'd0, 8'h37, 2'd1, 4'h0, 4'h0, "R2 direct load bit1");
        do_op(2'd0, 2'd0, 8'h37, 2'd0, 4'h0, 4'h0, "R2 direct load bit0");
        do_op(2'd0, 2'd3, 8'h37, 2'd3, 4'h0, 4'h0, "R2 mode3 as direct");

        // R4: page-plus-offset
        do_op(2'd0, 2'd2, 8'hB0, 2'd3, 4'h0, 4'h2, "R4 page 20h bit3");
        do_op(2'd0, 2'd2, 8'h05, 2'd0, 4'h0, 4'h2, "R4 page 25h bit0");
        do_op(2'd0, 2'd2, 8'hF0, 2'd0, 4'h0, 4'h2, "R4 page 20h bit0");

        // R6: stores, back-to-back after set/clear
        clrc();
        do_op(2'd1, 2'd2, 8'h00, 2'd3, 4'h0, 4'h2, "R6 store 0 to 20h bit3");
        setc();
        do_op(2'd1, 2'd0, 8'h20, 2'd0, 4'h0, 4'h0, "R6 store 1 to 20h bit0");
        clrc();
        do_op(2'd0, 2'd0, 8'h20, 2'd0, 4'h0, 4'h0, "R6 readback 20h bit0");
        do_op(2'd0, 2'd0, 8'h20, 2'd3, 4'h0, 4'h0, "R6 readback 20h bit3");

        // R3/R5: register-indexed port read, pin 0 clears carry
        @(negedge clk);
        pin_in[3:0] = 4'b0101;
        setc();
        do_op(2'd0, 2'd1, 8'hF1, 2'd0, 4'b0001, 4'h0, "R5 port0 bit1 pin low clears carry");
        pin_in[3:0] = 4'b0010;
        do_op(2'd0, 2'd1, 8'hF1, 2'd0, 4'b0001, 4'h0, "R3 port0 bit1 selected");
        check("R1 no pin driven by loads", pin_oe, 0);

        // R7: store into port 1 bit 2 through L
        setc();
        do_op(2'd1, 2'd1, 8'hF3, 2'd0, 4'b0110, 4'h0, "R7 port store keeps carry");
        check("R7 port1 bit2 output enabled only", pin_oe, 16'h0040);
        check("R7 port1 bit2 latch", pin_out[6], 1);

        // R8: output bit reads latch, input bit reads pin
        pin_in[6] = 1'b0;
        pin_in[7] = 1'b1;
        clrc();
        do_op(2'd0, 2'd0, 8'hF1, 2'd2, 4'h0, 4'h0, "R8 output bit reads latch");
        clrc();
        do_op(2'd0, 2'd0, 8'hF1, 2'd3, 4'h0, 4'h0, "R8 input bit reads pin high");
        pin_in[7] = 1'b0;
        do_op(2'd0, 2'd0, 8'hF1, 2'd3, 4'h0, 4'h0, "R8 input bit reads pin low");

        // R9: set and clear
        setc();
        check("R9 carry after set", carry, 1);
        clrc();
        check("R9 carry after clear", carry, 0);

        // R6/R2: varied stores and readbacks
        for (int k = 0; k < 8; k++) begin
            logic [7:0] ra;
            logic [1:0] rb;
            ra = 8'($urandom_range(0, 239));
            rb = 2'($urandom_range(0, 3));
            if (k % 2 == 0) setc(); else clrc();
            do_op(2'd1, 2'd0, ra, rb, 4'h0, 4'h0, "R6 varied store");
            @(negedge clk);
            do_op(2'd0, 2'd0, ra, rb, 4'h0, 4'h0, "R2 varied readback");
        end

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", carry_q.size() + wr_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule